// File: doc/BRIEF.md
# Tree-Path Iterator Register

This block is a cursor into a segment stored as a tree of fixed-size lines. Interior lines hold the IDs of child lines, and the leaf lines hold data words. A child ID of zero stands for a subtree that is entirely zero. The block does not keep a plain address. It keeps a copy of every line on the path from the root down to the current leaf, together with the entry index chosen at each level. The current element can therefore be read straight from the cached leaf, with no memory access.

Two commands are supported. A load takes a root line ID, a tree height and an element offset, and fetches the lines along that path. A next command advances to the following non-zero element. It walks sideways and upward through the cached lines, passes over zero child IDs without reading them, and fetches only the lines below the deepest level whose entry index stays the same. When no non-zero element remains, the block raises an end flag.

The line-read port uses valid/ready on the request side. `mem_req_id` must stay stable while `mem_req_valid` is high and `mem_req_ready` is low. The memory returns one line per accepted request, flagged by `mem_rsp_valid`, and the block always accepts that response. The command port also uses valid/ready, with `cmd_ready` low for as long as the block is busy.

Top module: `tpi_iterator`

## Requirements
- R1: A load with a non-zero root fetches the root line, then each child line along the offset's path, and ends with `cur_value` equal to the element at that offset and `at_end` low. When a child ID on the path is zero, fetching stops, the levels below count as zero lines, and `cur_value` is 0.
- R2: Encoding of lines and offsets. Entry j of a line is bits [j*WORD_W +: WORD_W]. A child ID is the low ID_W bits of its entry. An element is non-null when its word is non-zero. For height h, the offset uses its low h*FAN_LG bits, and the most significant FAN_LG-bit group indexes the root line.
- R3: `cur_offset` reports the current element's offset within the segment, using the same bit layout as the load offset. `cmd_op` is 0 for load and 1 for next.
- R4: On a next, a child ID of zero is skipped without any memory read.
- R5: When the next non-zero element lies in the cached leaf line, a next makes no memory read and keeps `busy` high for exactly one cycle.
- R6: On a next that moves to another leaf, only the levels below the deepest level whose entry index is unchanged are fetched, one read per level.
- R7: The height given with the load sets the number of path levels. With height 1 the root line is itself the leaf, and with height 2 there is one interior level.
- R8: A next that passes the last non-null element raises `at_end` and forces `cur_value` to 0. A next issued while `at_end` is high is accepted, changes nothing, and reads nothing.
- R9: A load with root ID 0 raises `at_end` at once, with no memory read and no busy cycle.
- R10: While `busy` is high, `cmd_ready` is low and a presented command is not taken.
- R11: While a line request is stalled by `mem_req_ready` low, `mem_req_valid` and `mem_req_id` hold steady, and the walk resumes when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle (not busy) |
| cmd_op | input | 1 | 0 = load, 1 = next |
| cmd_root | input | ID_W | Root line ID for a load |
| cmd_height | input | H_W | Tree height for a load, 1 to LVLS |
| cmd_offset | input | OFF_W | Element offset for a load |
| cur_value | output | WORD_W | Current element, 0 at end |
| cur_offset | output | OFF_W | Offset of the current element |
| at_end | output | 1 | Segment empty or exhausted |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Line read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_id | output | ID_W | Line ID requested |
| mem_rsp_valid | input | 1 | Line data returned |
| mem_rsp_line | input | FAN*WORD_W | Returned line content |

## Verification
Each line fetch costs two cycles: one to issue the request and one to take the response. A load that reaches the leaf is therefore due 2*h cycles after it is accepted. A next that stays in the cached leaf is due after exactly one busy cycle, and a next issued at end is due with no busy cycle at all. The driver counts busy cycles from the accepting edge and counts memory reads across each command. The scoreboard compares those counts, along with the value, offset and end flag, at the first falling edge after `busy` drops. The test also stalls `mem_req_ready` in the middle of a load and checks that the request holds during the stall and that the result is unchanged.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_SCAN} tpi_state_e;
  typedef enum logic {OP_LOAD = 1'b0, OP_NEXT = 1'b1} tpi_op_e;
endpackage

// File: rtl/tpi_first_set.sv
module tpi_first_set #(
  parameter int FAN_LG = 2,
  parameter int WORD_W = 16,
  localparam int FAN = 1 << FAN_LG
) (
  input  logic [FAN*WORD_W-1:0] line,
  input  logic [FAN_LG:0]       start,
  output logic                  found,
  output logic [FAN_LG-1:0]     pos
);
  logic [FAN-1:0] hit;

  for (genvar j = 0; j < FAN; j++) begin : g_hit
    assign hit[j] = (line[j*WORD_W +: WORD_W] != '0) && ((FAN_LG+1)'(j) >= start);
  end

  always_comb begin
    found = |hit;
    pos   = '0;
    for (int j = FAN - 1; j >= 0; j--) begin
      if (hit[j]) pos = FAN_LG'(j);
    end
  end
endmodule

// File: rtl/tpi_offset_map.sv
module tpi_offset_map #(
  parameter int LVLS   = 3,
  parameter int FAN_LG = 2,
  localparam int OFF_W = LVLS * FAN_LG,
  localparam int H_W   = $clog2(LVLS + 1)
) (
  input  logic [OFF_W-1:0]             offset_in,
  input  logic [H_W-1:0]               split_height,
  input  logic [H_W-1:0]               pack_height,
  input  logic [LVLS-1:0][FAN_LG-1:0]  cur_idx,
  output logic [LVLS-1:0][FAN_LG-1:0]  split_idx,
  output logic [OFF_W-1:0]             packed_off
);
  always_comb begin
    for (int l = 0; l < LVLS; l++) begin
      split_idx[l] = '0;
      if (l < int'(split_height))
        split_idx[l] = FAN_LG'(offset_in >> ((int'(split_height) - 1 - l) * FAN_LG));
    end
    packed_off = '0;
    for (int l = 0; l < LVLS; l++) begin
      if (l < int'(pack_height))
        packed_off = (packed_off << FAN_LG) | OFF_W'(cur_idx[l]);
    end
  end
endmodule

// File: rtl/tpi_iterator.sv
module tpi_iterator #(
  parameter int ID_W   = 8,
  parameter int WORD_W = 16,
  parameter int FAN_LG = 2,
  parameter int LVLS   = 3,
  localparam int FAN    = 1 << FAN_LG,
  localparam int LINE_W = FAN * WORD_W,
  localparam int OFF_W  = LVLS * FAN_LG,
  localparam int H_W    = $clog2(LVLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ID_W-1:0]   cmd_root,
  input  logic [H_W-1:0]    cmd_height,
  input  logic [OFF_W-1:0]  cmd_offset,
  output logic [WORD_W-1:0] cur_value,
  output logic [OFF_W-1:0]  cur_offset,
  output logic              at_end,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ID_W-1:0]   mem_req_id,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line
);
  import tpi_pkg::*;

  tpi_state_e                 state;
  logic                       is_load;
  logic [H_W-1:0]             lvl;
  logic [FAN_LG:0]            start;
  logic [H_W-1:0]             height_q;
  logic [LVLS-1:0][LINE_W-1:0] line_q;
  logic [LVLS-1:0][FAN_LG-1:0] idx_q;
  logic                       end_q;
  logic [ID_W-1:0]            req_id_q;

  logic [LVLS-1:0][FAN_LG-1:0] split_idx;
  logic [H_W-1:0]             leaf_lvl;
  logic [LINE_W-1:0]          scan_line;
  logic                       f_found;
  logic [FAN_LG-1:0]          f_pos;
  logic                       cmd_fire;
  logic [ID_W-1:0]            load_child;

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] ln,
                                                input logic [FAN_LG-1:0] j);
    return ln[int'(j)*WORD_W +: WORD_W];
  endfunction

  assign leaf_lvl  = height_q - 1'b1;
  assign scan_line = line_q[lvl];
  assign busy      = (state != ST_IDLE);
  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign at_end    = end_q;
  assign cur_value = end_q ? '0 : word_of(line_q[leaf_lvl], idx_q[leaf_lvl]);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_id    = req_id_q;
  assign load_child    = word_of(mem_rsp_line, idx_q[lvl])[ID_W-1:0];

  tpi_first_set #(.FAN_LG(FAN_LG), .WORD_W(WORD_W)) i_first (
    .line(scan_line), .start(start), .found(f_found), .pos(f_pos)
  );

  tpi_offset_map #(.LVLS(LVLS), .FAN_LG(FAN_LG)) i_offmap (
    .offset_in(cmd_offset), .split_height(cmd_height), .pack_height(height_q),
    .cur_idx(idx_q), .split_idx(split_idx), .packed_off(cur_offset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_load  <= 1'b0;
      lvl      <= '0;
      start    <= '0;
      height_q <= H_W'(1);
      line_q   <= '0;
      idx_q    <= '0;
      end_q    <= 1'b1;
      req_id_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_fire) begin
          if (cmd_op == OP_LOAD) begin
            height_q <= cmd_height;
            idx_q    <= split_idx;
            is_load  <= 1'b1;
            lvl      <= '0;
            req_id_q <= cmd_root;
            end_q    <= (cmd_root == '0);
            if (cmd_root != '0) state <= ST_REQ;
          end else if (!end_q) begin
            is_load <= 1'b0;
            lvl     <= leaf_lvl;
            start   <= {1'b0, idx_q[leaf_lvl]} + (FAN_LG+1)'(1);
            state   <= ST_SCAN;
          end
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          line_q[lvl] <= mem_rsp_line;
          if (!is_load) begin
            start <= '0;
            state <= ST_SCAN;
          end else if (lvl == leaf_lvl) begin
            state <= ST_IDLE;
          end else if (load_child == '0) begin
            for (int l = 0; l < LVLS; l++)
              if (l > int'(lvl)) line_q[l] <= '0;
            state <= ST_IDLE;
          end else begin
            lvl      <= lvl + 1'b1;
            req_id_q <= load_child;
            state    <= ST_REQ;
          end
        end
        ST_SCAN: begin
          if (f_found) begin
            idx_q[lvl] <= f_pos;
            if (lvl == leaf_lvl) begin
              state <= ST_IDLE;
            end else begin
              req_id_q <= word_of(scan_line, f_pos)[ID_W-1:0];
              lvl      <= lvl + 1'b1;
              state    <= ST_REQ;
            end
          end else if (lvl == '0) begin
            end_q <= 1'b1;
            state <= ST_IDLE;
          end else begin
            lvl   <= lvl - 1'b1;
            start <= {1'b0, idx_q[lvl - 1'b1]} + (FAN_LG+1)'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: zero root gives an empty segment with no walk
  p_root_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_op == OP_LOAD && cmd_root == '0 |=> at_end && !busy && !mem_req_valid);

  // R11: stalled request holds its ID
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_id));

  // R10: a command presented while busy leaves the loaded height untouched
  p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> $stable(height_q));

  // R8: next at end is quiet
  p_end_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at_end && !busy && cmd_valid && cmd_op == OP_NEXT |=> at_end && !busy && !mem_req_valid);

  // R3: a completed next that is not at end lands on a non-zero element
  p_next_nonnull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !is_load && !at_end |-> cur_value != '0);

  // R5: a hit in the cached leaf finishes without a request
  p_leaf_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SCAN && lvl == leaf_lvl && f_found |=> !busy && !mem_req_valid);
endmodule

// File: tb/test_tpi_iterator.sv
`timescale 1ns/1ps
module test_tpi_iterator;
  localparam int ID_W = 8, WORD_W = 16, FAN_LG = 2, LVLS = 3;
  localparam int LINE_W = 4 * WORD_W, OFF_W = 6, H_W = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_op = 0;
  logic [ID_W-1:0] cmd_root = 0;
  logic [H_W-1:0] cmd_height = 0;
  logic [OFF_W-1:0] cmd_offset = 0;
  logic cmd_ready, at_end, busy, mem_req_valid;
  logic [WORD_W-1:0] cur_value;
  logic [OFF_W-1:0] cur_offset;
  logic [ID_W-1:0] mem_req_id;
  logic mem_req_ready;
  logic stall = 0;
  logic mem_rsp_valid = 0;
  logic [LINE_W-1:0] mem_rsp_line = 0;

  always #2 clk = ~clk;
  assign mem_req_ready = !stall;

  tpi_iterator i_tpi_iterator (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_root(cmd_root), .cmd_height(cmd_height), .cmd_offset(cmd_offset),
    .cur_value(cur_value), .cur_offset(cur_offset), .at_end(at_end), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_id(mem_req_id),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
  );

  logic [WORD_W-1:0] elem [64];
  logic [LINE_W-1:0] mem_lines [int];
  int leaf_id [16];
  int node_id [4];
  int root_id;
  int reads = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_line  <= mem_lines.exists(int'(mem_req_id)) ? mem_lines[int'(mem_req_id)] : '0;
    if (mem_req_valid && mem_req_ready) reads <= reads + 1;
  end

  typedef struct {
    logic [WORD_W-1:0] value;
    int offset;
    logic end_f;
    int rd;
    int cyc;
    bit chk_cyc;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  int base_reads, last_cycles;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(at_end == e.end_f, e.tag, "at_end", int'(at_end), int'(e.end_f));
      check(cur_value == e.value, e.tag, "value", int'(cur_value), int'(e.value));
      if (!e.end_f) check(int'(cur_offset) == e.offset, e.tag, "offset", int'(cur_offset), e.offset);
      check(reads - base_reads == e.rd, e.tag, "reads", reads - base_reads, e.rd);
      if (e.chk_cyc) check(last_cycles == e.cyc, e.tag, "busy cycles", last_cycles, e.cyc);
    end
  end

  // bench model state
  int m_base, m_h, m_cur;
  bit m_end = 1;

  function automatic bit span_nz(input int lo, input int n);
    for (int i = lo; i < lo + n; i++) if (elem[i] != 0) return 1;
    return 0;
  endfunction

  task automatic drive(input logic op, input int root, input int h, input int off);
    wait (exp_q.size() == 0);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_root = ID_W'(root);
    cmd_height = H_W'(h); cmd_offset = OFF_W'(off);
    base_reads = reads;
    @(negedge clk);
    cmd_valid = 0;
    last_cycles = 0;
    while (busy) begin last_cycles++; @(negedge clk); end
  endtask

  task automatic do_load(input int root, input int base, input int h, input int off, input string tag);
    exp_t e;
    int rd = 0;
    drive(1'b0, root, h, off);
    m_base = base; m_h = h; m_cur = off; m_end = (root == 0);
    if (root != 0) begin
      rd = 1;
      for (int l = 0; l < h - 1; l++) begin
        int sz = 1 << (2 * (h - 1 - l));
        if (!span_nz(base + (off / sz) * sz, sz)) break;
        rd++;
      end
    end
    e.value = m_end ? '0 : elem[base + off]; e.offset = off; e.end_f = m_end;
    e.rd = rd; e.cyc = 2 * rd; e.chk_cyc = 1; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_next(input string tag);
    exp_t e;
    int nxt = -1, rd = 0;
    bit was_end = m_end;
    drive(1'b1, 0, 0, 0);
    if (!m_end) begin
      for (int i = m_cur + 1; i < (1 << (2 * m_h)); i++)
        if (elem[m_base + i] != 0) begin nxt = i; break; end
      if (nxt < 0) m_end = 1;
      else begin
        for (int l = 1; l < m_h; l++)
          if ((nxt >> (2 * (m_h - l))) != (m_cur >> (2 * (m_h - l)))) rd++;
        m_cur = nxt;
      end
    end
    e.value = m_end ? '0 : elem[m_base + m_cur]; e.offset = m_cur; e.end_f = m_end; e.rd = rd;
    e.chk_cyc = was_end || (rd == 0 && !m_end && (nxt >> 2) == 0) ? 0 : 0;
    e.cyc = 0;
    if (was_end) begin e.chk_cyc = 1; e.cyc = 0; end
    else if (!m_end && rd == 0) begin e.chk_cyc = 1; e.cyc = 1; end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    // segment content: non-zero at 1,2,3,6,17,50,63
    for (int i = 0; i < 64; i++) elem[i] = '0;
    elem[1] = 16'h101; elem[2] = 16'h102; elem[3] = 16'h103; elem[6] = 16'h106;
    elem[17] = 16'h111; elem[50] = 16'h132; elem[63] = 16'h13f;
    begin
      int nid = 1;
      for (int b = 0; b < 16; b++) begin
        leaf_id[b] = 0;
        if (span_nz(4 * b, 4)) begin
          leaf_id[b] = nid;
          mem_lines[nid] = {elem[4*b+3], elem[4*b+2], elem[4*b+1], elem[4*b]};
          nid++;
        end
      end
      for (int n = 0; n < 4; n++) begin
        node_id[n] = 0;
        if (span_nz(16 * n, 16)) begin
          node_id[n] = nid;
          mem_lines[nid] = {16'(leaf_id[4*n+3]), 16'(leaf_id[4*n+2]), 16'(leaf_id[4*n+1]), 16'(leaf_id[4*n])};
          nid++;
        end
      end
      root_id = nid;
      mem_lines[nid] = {16'(node_id[3]), 16'(node_id[2]), 16'(node_id[1]), 16'(node_id[0])};
    end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && at_end && cur_value == 0 && !mem_req_valid, "reset", "idle state",
          {busy, at_end, mem_req_valid}, 3'b010);

    do_load(root_id, 0, 3, 1, "R1 R2 load h3");
    do_next("R5 leaf hit");
    do_next("R5 leaf hit 2");
    do_next("R6 next leaf");
    do_next("R6 next subtree");
    do_next("R4 skip zero child");
    do_next("R3 offset 63");
    do_next("R8 pass last");
    do_next("R8 next at end");
    do_load(root_id, 0, 3, 33, "R1 R4 load in zero subtree");
    do_next("R6 from zero path");
    do_load(0, 0, 3, 0, "R9 zero root");
    do_load(node_id[0], 0, 2, 6, "R7 height 2");
    do_next("R7 R8 height 2 end");
    do_load(leaf_id[0], 0, 1, 0, "R7 height 1");
    do_next("R7 R5 h1 next");
    do_next("R7 h1 next2");
    do_next("R7 h1 next3");
    do_next("R7 R8 h1 end");

    // R10: command pulsed while busy is not taken
    wait (exp_q.size() == 0);
    fork
      do_load(root_id, 0, 3, 17, "R10 refused cmd");
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(busy && !cmd_ready, "R10", "busy/ready", {busy, cmd_ready}, 2'b10);
        cmd_valid = 1; cmd_root = 0;
        @(negedge clk);
        cmd_valid = 0; cmd_root = ID_W'(root_id);
      end
    join

    // R11: stall the line request
    wait (exp_q.size() == 0);
    stall = 1;
    fork
      do_load(root_id, 0, 3, 50, "R11 stalled load");
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(mem_req_valid && mem_req_id == ID_W'(root_id), "R11", "held request",
              int'(mem_req_id), root_id);
        stall = 0;
      end
    join
    exp_q[0].chk_cyc = 0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule